// File: doc/BRIEF.md
# Compare-Point PWM Channel with Two-Stage Prescaler

This block drives one pulse-width-modulated output. The input clock first passes through a prescaler. The prescaler has a power-of-two stage followed by a linear stage, and it produces one count tick every `(divLin+1) * 2^divExp` input clocks. Each tick advances an 8-bit period counter, which runs from 0 up to a programmed top value and then wraps. Two compare values set the waveform: the level goes high at a rise point and low at a fall point.

Software programs the channel through two 32-bit words, each with its own write strobe. The setup word holds the divider fields and the mode bits. The shape word holds the period top, the fall point and the rise point. Three of these settings are shadowed: the divider fields, the period and the compare points. Normally they take effect at the next period boundary, which keeps every period glitch-free. A sync-off mode applies them at once. The mode bits (pin enable, open drain, inversion, counting enable and sync-off) act straight away, so stopping the channel does not finish the current period.

Top module: `pwm_edge_channel`

## Requirements
- R1: Setup word fields: `divLin` in bits [7:0], `divExp` in bits [11:8], pin enable in bit 12, open-drain in bit 13, invert in bit 14, counting enable in bit 16, sync-off in bit 17. Each period lasts `(divLin+1) * 2^divExp * (top+1)` clocks.
- R2: Shape word fields: rise point in bits [7:0], fall point in bits [15:8], period top in bits [31:24]. For counter value c, the level is high when rise <= c < fall if rise < fall, and high when c >= rise or c < fall if rise > fall.
- R3: When the rise point equals the fall point, the level is high for the whole period.
- R4: A rise point of 0 makes every period start high. Setting counting enable starts the counter at 0.
- R5: While pin enable is 0, `pwmOut` is 0.
- R6: While counting enable is 0, the period counter and the prescaler are held at 0 and the level is 0, whatever the invert setting. Shape and divider writes made in this state are in force once counting resumes.
- R7: The invert bit flips `pwmOut` in the cycle after its write. It does not disturb the counter phase.
- R8: With open-drain set, `pwmOe` is high only while `pwmOut` is 0. Without it, `pwmOe` is always 1.
- R9: With sync-off clear and counting enabled, new shape and divider values take effect only at the start of the next period.
- R10: With sync-off set, a shape write takes effect in the cycle after the write.
- R11: Clearing pin enable or counting enable mid-period forces `pwmOut` to 0 in the next cycle.
- R12: After reset, `pwmOut` is 0 and `pwmOe` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| setupWe | input | 1 | Write strobe for the setup word |
| setupData | input | 32 | Setup word value |
| shapeWe | input | 1 | Write strobe for the shape word |
| shapeData | input | 32 | Shape word value |
| pwmOut | output | 1 | Output level |
| pwmOe | output | 1 | Output drive enable |

## Verification
Some behaviours are checked by assertions on every cycle:
- the pin-enable gate on `pwmOut`;
- the open-drain relation between `pwmOe` and `pwmOut`;
- the counter being held at 0 while stopped, and its wrap at the top;
- the full-duty case of equal compare points;
- the active settings staying frozen except at a period boundary when sync is on.

The actual duty ratios, the prescaler length and the waveform shape for each compare ordering can only be shown by the bench. The same holds for the phase at which a new shape takes effect, both with and without sync, and for the immediate effect of inversion and disable.

// File: rtl/pwm_edge_pkg.sv
package pwm_edge_pkg;
  parameter int CNT_W  = 8;
  parameter int DIVL_W = 8;
  parameter int DIVE_W = 4;
  localparam int P2_W  = (1 << DIVE_W) - 1;

  // setup word bit positions
  localparam int DIVL_LSB = 0;
  localparam int DIVE_LSB = 8;
  localparam int PIN_BIT  = 12;
  localparam int OD_BIT   = 13;
  localparam int INV_BIT  = 14;
  localparam int RUN_BIT  = 16;
  localparam int SYNC_BIT = 17;
  // shape word bit positions
  localparam int RISE_LSB = 0;
  localparam int FALL_LSB = 8;
  localparam int TOP_LSB  = 24;

  typedef struct packed {
    logic [DIVL_W-1:0] divLin;
    logic [DIVE_W-1:0] divExp;
    logic [CNT_W-1:0]  top;
    logic [CNT_W-1:0]  rise;
    logic [CNT_W-1:0]  fall;
  } shape_cfg_t;

  typedef struct packed {
    logic clkRun;
    logic pinOn;
    logic openDrain;
    logic invert;
    logic syncOff;
  } mode_strobe_t;
endpackage

// File: rtl/pwm_edge_ctrl.sv
module pwm_edge_ctrl
  import pwm_edge_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         setupWe,
  input  logic [31:0]  setupData,
  input  logic         shapeWe,
  input  logic [31:0]  shapeData,
  input  logic         boundary,
  output shape_cfg_t   activeCfg,
  output mode_strobe_t strobes
);
  shape_cfg_t pendCfg;
  logic       dirty;
  logic       loadNow;
  logic       unusedBits;

  assign unusedBits = ^{setupData[31:18], setupData[15],
                        shapeData[23:16], 1'b0};

  // shadow copy moves to active: at once when sync is off or stopped,
  // otherwise only on the tick that wraps the period counter
  assign loadNow = dirty && (strobes.syncOff || !strobes.clkRun || boundary);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      strobes   <= '0;
      pendCfg   <= '0;
      activeCfg <= '0;
      dirty     <= 1'b0;
    end else begin
      if (setupWe) begin
        strobes.clkRun    <= setupData[RUN_BIT];
        strobes.pinOn     <= setupData[PIN_BIT];
        strobes.openDrain <= setupData[OD_BIT];
        strobes.invert    <= setupData[INV_BIT];
        strobes.syncOff   <= setupData[SYNC_BIT];
        pendCfg.divLin    <= setupData[DIVL_LSB +: DIVL_W];
        pendCfg.divExp    <= setupData[DIVE_LSB +: DIVE_W];
      end
      if (shapeWe) begin
        pendCfg.top  <= shapeData[TOP_LSB +: CNT_W];
        pendCfg.fall <= shapeData[FALL_LSB +: CNT_W];
        pendCfg.rise <= shapeData[RISE_LSB +: CNT_W];
      end
      if (loadNow) activeCfg <= pendCfg;
      dirty <= (dirty && !loadNow) || setupWe || shapeWe;
    end
  end
endmodule

// File: rtl/pwm_edge_datapath.sv
module pwm_edge_datapath
  import pwm_edge_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  shape_cfg_t       cfg,
  input  mode_strobe_t     strobes,
  output logic             boundary,
  output logic [CNT_W-1:0] periodCnt,
  output logic             pwmOut,
  output logic             pwmOe
);
  logic [P2_W-1:0]   p2Cnt;
  logic [P2_W-1:0]   p2Mask;
  logic [DIVL_W-1:0] linCnt;
  logic p2Done, linDone, tick, wrap;
  logic wave, runLevel, pinLevel;
  logic unusedMode;

  assign unusedMode = strobes.syncOff;

  assign p2Mask  = ~({P2_W{1'b1}} << cfg.divExp);
  assign p2Done  = p2Cnt >= p2Mask;
  assign linDone = linCnt >= cfg.divLin;
  assign tick    = p2Done && linDone;
  assign wrap    = periodCnt >= cfg.top;
  assign boundary = tick && wrap;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      p2Cnt     <= '0;
      linCnt    <= '0;
      periodCnt <= '0;
    end else if (!strobes.clkRun) begin
      p2Cnt     <= '0;
      linCnt    <= '0;
      periodCnt <= '0;
    end else begin
      p2Cnt <= p2Done ? '0 : p2Cnt + 1'b1;
      if (p2Done) linCnt <= linDone ? '0 : linCnt + 1'b1;
      if (tick)   periodCnt <= wrap ? '0 : periodCnt + 1'b1;
    end
  end

  always_comb begin
    if (cfg.rise == cfg.fall)
      wave = 1'b1;
    else if (cfg.rise < cfg.fall)
      wave = (periodCnt >= cfg.rise) && (periodCnt < cfg.fall);
    else
      wave = (periodCnt >= cfg.rise) || (periodCnt < cfg.fall);
  end

  assign runLevel = strobes.clkRun && (wave ^ strobes.invert);
  assign pinLevel = strobes.pinOn && runLevel;
  assign pwmOut   = pinLevel;
  assign pwmOe    = strobes.openDrain ? !pinLevel : 1'b1;
endmodule

// File: rtl/pwm_edge_channel.sv
module pwm_edge_channel
  import pwm_edge_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        setupWe,
  input  logic [31:0] setupData,
  input  logic        shapeWe,
  input  logic [31:0] shapeData,
  output logic        pwmOut,
  output logic        pwmOe
);
  shape_cfg_t       activeCfg;
  mode_strobe_t     strobes;
  logic             boundary;
  logic [CNT_W-1:0] periodCnt;

  pwm_edge_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .setupWe(setupWe), .setupData(setupData),
    .shapeWe(shapeWe), .shapeData(shapeData),
    .boundary(boundary),
    .activeCfg(activeCfg), .strobes(strobes)
  );

  pwm_edge_datapath u_dp (
    .clk(clk), .rstN(rstN),
    .cfg(activeCfg), .strobes(strobes),
    .boundary(boundary), .periodCnt(periodCnt),
    .pwmOut(pwmOut), .pwmOe(pwmOe)
  );
endmodule

// File: rtl/pwm_edge_chk.sv
module pwm_edge_chk
  import pwm_edge_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             pwmOut,
  input logic             pwmOe,
  input mode_strobe_t     strobes,
  input shape_cfg_t       activeCfg,
  input logic             boundary,
  input logic [CNT_W-1:0] periodCnt
);
  // R5
  pin_off_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.pinOn |-> !pwmOut);

  // R6
  stopped_cnt_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.clkRun |=> periodCnt == '0);

  // R8
  open_drain_oe_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.openDrain |-> (pwmOe == !pwmOut));

  // R8
  push_pull_oe_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.openDrain |-> pwmOe);

  // R3
  full_duty_chk: assert property (@(posedge clk) disable iff (!rstN)
    (activeCfg.rise == activeCfg.fall && strobes.clkRun && strobes.pinOn
     && !strobes.invert) |-> pwmOut);

  // R9
  sync_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.clkRun && !strobes.syncOff && !boundary) |=> $stable(activeCfg));

  // R1
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    boundary |=> periodCnt == '0);
endmodule

bind pwm_edge_channel pwm_edge_chk u_chk (
  .clk(clk), .rstN(rstN), .pwmOut(pwmOut), .pwmOe(pwmOe),
  .strobes(strobes), .activeCfg(activeCfg),
  .boundary(boundary), .periodCnt(periodCnt)
);

// File: tb/test_pwm_edge_channel.sv
module test_pwm_edge_channel;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        setupWe = 1'b0;
  logic [31:0] setupData = '0;
  logic        shapeWe = 1'b0;
  logic [31:0] shapeData = '0;
  logic        pwmOut, pwmOe;
  int checkCnt = 0;
  int failCnt = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pwm_edge_channel i_pwm_edge_channel (
    .clk(clk), .rstN(rstN),
    .setupWe(setupWe), .setupData(setupData),
    .shapeWe(shapeWe), .shapeData(shapeData),
    .pwmOut(pwmOut), .pwmOe(pwmOe)
  );

  // setup: run=bit16 pin=bit12 od=bit13 inv=bit14; shape: top[31:24] fall[15:8] rise[7:0]
  localparam int NV = 8;
  localparam logic [31:0] V_SETUP [NV] = '{32'h11000, 32'h11000, 32'h11000, 32'h11102,
                                           32'h15000, 32'h10000, 32'h05000, 32'h13000};
  localparam logic [31:0] V_SHAPE [NV] = '{32'h09000702, 32'h09000208, 32'h05000404,
                                           32'h03000100, 32'h09000502, 32'h09000702,
                                           32'h09000702, 32'h09000702};
  localparam int V_WIN [NV] = '{20, 20, 12, 48, 20, 20, 20, 20};
  localparam int V_HI  [NV] = '{10,  8, 12, 12, 14,  0,  0, 10};
  localparam int V_OE  [NV] = '{20, 20, 12, 48, 20, 20, 20, 10};
  localparam string V_REQ [NV] = '{"R2", "R2", "R3", "R1", "R7", "R5", "R6", "R8"};

  task automatic check(input string req, input int actual, input int expected);
    checkCnt++;
    if (actual != expected) begin
      failCnt++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  task automatic writeSetup(input logic [31:0] v);
    setupWe = 1'b1; setupData = v;
    @(posedge clk); @(negedge clk);
    setupWe = 1'b0;
  endtask

  task automatic writeShape(input logic [31:0] v);
    shapeWe = 1'b1; shapeData = v;
    @(posedge clk); @(negedge clk);
    shapeWe = 1'b0;
  endtask

  // stop, load shape, start: counter sits at 0 on return
  task automatic restart(input logic [31:0] s, input logic [31:0] d);
    writeSetup(s & ~32'h10000);
    writeShape(d);
    writeSetup(s);
  endtask

  task automatic waitCycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #200000;
    if (!done) begin
      failCnt++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    // R12 reset state
    check("R12 out", int'(pwmOut), 0);
    check("R12 oe", int'(pwmOe), 1);
    rstN = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      int hi, oe;
      hi = 0; oe = 0;
      restart(V_SETUP[v], V_SHAPE[v]);
      for (int c = 0; c < V_WIN[v]; c++) begin
        hi += int'(pwmOut);
        oe += int'(pwmOe);
        @(negedge clk);
      end
      check({V_REQ[v], " high count"}, hi, V_HI[v]);
      check({V_REQ[v], " oe count"}, oe, V_OE[v]);
    end

    // R4 rise 0 starts high; R9 sync update at next period
    restart(32'h11000, 32'h09000500);
    check("R4 start high", int'(pwmOut), 1);
    waitCycles(2);
    writeShape(32'h09000800);
    waitCycles(2);
    check("R9 old fall kept", int'(pwmOut), 0);
    waitCycles(10);
    check("R9 new fall next period", int'(pwmOut), 1);

    // R10 sync off: shape applies the cycle after the write
    restart(32'h31000, 32'h09000500);
    waitCycles(2);
    writeShape(32'h09000800);
    waitCycles(2);
    check("R10 immediate fall", int'(pwmOut), 1);

    // R7 invert mid period
    restart(32'h11000, 32'h09000500);
    waitCycles(1);
    check("R7 before invert", int'(pwmOut), 1);
    writeSetup(32'h15000);
    check("R7 inverted now", int'(pwmOut), 0);

    // R11 immediate disable
    restart(32'h11000, 32'h09000500);
    waitCycles(1);
    writeSetup(32'h10000);
    check("R11 pin off", int'(pwmOut), 0);
    writeSetup(32'h11000);
    check("R11 pin back on", int'(pwmOut), 1);
    writeSetup(32'h01000);
    check("R11 run off", int'(pwmOut), 0);

    // R6 shape written while stopped is used on restart
    writeShape(32'h03000303);
    writeSetup(32'h11000);
    check("R6 new shape after resume", int'(pwmOut), 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end
endmodule